// File: doc/BRIEF.md
# Ramped Gain with Soft Mute

This block multiplies a stream of signed audio samples by a programmable gain. The gain never jumps. A new target moves the applied gain toward it by one gain step for each accepted sample, so volume changes and fades are free of clicks. A mute control reuses the same ramp to fade the applied gain down to zero. When mute is released, the gain ramps back up to the stored target.

Gains are 9-bit unsigned codes in units of 1/128. Code 128 is unity and code 256 is the ceiling of 2.0. The usual working value is code 127, just under unity, which leaves headroom for ripple in later filters. Each product is rounded and then saturated to the sample width. The result appears one register stage after its input sample. A status output reports when the applied gain has reached its destination.

Top module: `ramp_gain`

## Requirements
- R1: After reset the applied gain and the stored target are both code 127, `out_valid` is low and `gain_settled` is high.
- R2: `out_valid` equals `in_valid` of the previous clock. When it is high, `out_sample` equals (x*g + 64) >> 7, shifted arithmetically. Here x is the sample accepted on that previous clock and g is the applied gain code before that clock's ramp step.
- R3: A target write (`tgt_wr` high) stores `tgt_code`, and any value above 256 is stored as 256.
- R4: On each clock with `in_valid` high, the applied gain moves exactly one code toward its destination. On clocks with `in_valid` low it does not change. The destination is 0 while `mute` is high and the stored target otherwise. A target written on a given clock first steers the ramp on the next clock.
- R5: While `mute` is high, the applied gain falls by one code per accepted sample until it is 0, then stays at 0.
- R6: After `mute` goes low, the applied gain rises or falls by one code per accepted sample to the stored target.
- R7: A target write while `mute` is high changes only the stored target. The gain keeps ramping to 0, and the ramp toward the new target starts after mute is released.
- R8: A target change during a ramp reverses or redirects the ramp at once, starting from the current applied gain.
- R9: Results beyond the 24-bit range are clamped to 8388607 or -8388608.
- R10: `gain_settled` is high exactly when the applied gain equals the current destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 24 | Signed input sample |
| tgt_wr | input | 1 | Target gain write strobe |
| tgt_code | input | 9 | Target gain code, 128 = unity |
| mute | input | 1 | Soft mute request |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 24 | Scaled, rounded, saturated sample |
| gain_settled | output | 1 | Applied gain equals its destination |

## Verification
Scaled samples and `out_valid` are due one clock after the sample is presented. `gain_settled` is combinational and reflects the gain left by the previous accepted sample. The bench drives inputs on the falling edge and samples `gain_settled` before the next rising edge. It then samples `out_valid` and `out_sample` just after that edge. A behavioural model in the bench holds the applied gain and the target as integers and is stepped with the same timing. Because each output sample is computed with the gain before its own step, a probe sample of 128 reads the applied gain back exactly.

// File: rtl/ramp_gain.sv
module ramp_gain #(
  parameter int DW         = 24,
  parameter int GW         = 9,
  parameter int FRAC       = 7,
  parameter int RESET_GAIN = 127
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  input  logic          tgt_wr,
  input  logic [GW-1:0] tgt_code,
  input  logic          mute,
  output logic          out_valid,
  output logic [DW-1:0] out_sample,
  output logic          gain_settled
);
  localparam int PW = DW + GW + 1;
  localparam logic [GW-1:0] GMAX = GW'(2 << FRAC);
  localparam logic signed [PW-1:0] SMAX = PW'((64'sd1 <<< (DW-1)) - 1);
  localparam logic signed [PW-1:0] SMIN = -PW'(64'sd1 <<< (DW-1));
  localparam logic signed [PW-1:0] HALF = PW'(1 << (FRAC-1));

  logic [GW-1:0] gain_q, tgt_q, dest;
  logic signed [PW-1:0] prod, rnd, shf;
  logic [DW-1:0] sat;

  assign dest = mute ? '0 : tgt_q;
  assign gain_settled = (gain_q == dest);

  assign prod = PW'($signed(in_sample)) * $signed({1'b0, gain_q});
  assign rnd  = prod + HALF;
  assign shf  = rnd >>> FRAC;
  assign sat  = (shf > SMAX) ? SMAX[DW-1:0] :
                (shf < SMIN) ? SMIN[DW-1:0] : shf[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q    <= GW'(RESET_GAIN);
      tgt_q     <= GW'(RESET_GAIN);
      out_valid <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sample <= sat;
        if (gain_q < dest)      gain_q <= gain_q + 1'b1;
        else if (gain_q > dest) gain_q <= gain_q - 1'b1;
      end
      if (tgt_wr) tgt_q <= (tgt_code > GMAX) ? GMAX : tgt_code;
    end
  end

  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q <= GMAX && tgt_q <= GMAX); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(gain_q)); // R4
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gain_q < dest) |=> gain_q == $past(gain_q) + 1'b1); // R4
  AST_MUTE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mute && gain_q != '0) |=> gain_q == $past(gain_q) - 1'b1); // R5
  AST_MUTE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (mute && gain_q == '0) |=> gain_q == '0); // R5
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
endmodule

// File: tb/ramp_gain_tb_top.sv
module ramp_gain_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, tgt_wr = 0, mute = 0;
  logic [23:0] in_sample = '0;
  logic [8:0] tgt_code = '0;
  logic out_valid, gain_settled;
  logic [23:0] out_sample;
  int n_run = 0, n_fail = 0;
  int mg = 127, mt = 127;
  logic done = 0;

  always #2.5 clk = ~clk;

  ramp_gain dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .tgt_wr(tgt_wr), .tgt_code(tgt_code), .mute(mute), .out_valid(out_valid),
    .out_sample(out_sample), .gain_settled(gain_settled));

  function automatic int scale(int x, int g);
    longint p;
    p = (longint'(x) * g + 64) >>> 7;
    if (p > 8388607) p = 8388607;
    if (p < -8388608) p = -8388608;
    return int'(p);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit v, int x, bit we, int d, bit m, string req);
    int dest, ex;
    @(negedge clk);
    in_valid = v; in_sample = 24'(x); tgt_wr = we; tgt_code = 9'(d); mute = m;
    #1;
    dest = m ? 0 : mt;
    check(gain_settled == (mg == dest), {req, " R10 settled"}, gain_settled, mg == dest);
    ex = scale(x, mg);
    if (v) begin
      if (mg < dest) mg++;
      else if (mg > dest) mg--;
    end
    if (we) mt = (d > 256) ? 256 : d;
    @(posedge clk); #1;
    check(out_valid == v, {req, " R2 valid"}, out_valid, v);
    if (v) check($signed(out_sample) == ex, {req, " R2 sample"}, $signed(out_sample), ex);
  endtask

  task automatic probe(int n, bit m, string req);
    for (int i = 0; i < n; i++) step(1, 128, 0, 0, m, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check(out_valid == 0, "R1 valid", out_valid, 0);
    check(gain_settled == 1, "R1 settled", gain_settled, 1);
    step(1, 128, 0, 0, 0, "R1 gain127");
    step(1, -1000, 0, 0, 0, "R2 neg");
    step(1, 12345, 0, 0, 0, "R2 pos");
    step(0, 77, 0, 0, 0, "R2 idle");
    step(1, 1, 0, 0, 0, "R2 round");
    step(1, 0, 1, 135, 0, "R4 write");
    probe(10, 0, "R4 ramp up");
    step(0, 0, 1, 120, 0, "R4 idle write");
    step(0, 0, 0, 0, 0, "R4 idle hold");
    probe(4, 0, "R8 reverse");
    step(1, 128, 1, 140, 0, "R8 redirect");
    probe(25, 0, "R8 settle");
    step(1, 0, 1, 400, 0, "R3 clamp");
    probe(130, 0, "R3 to 256");
    step(1, 8388607, 0, 0, 0, "R9 sat hi");
    step(1, -8388608, 0, 0, 0, "R9 sat lo");
    step(1, 8000000, 0, 0, 0, "R9 sat hi2");
    step(1, 0, 1, 127, 0, "R6 retarget");
    probe(140, 0, "R6 down");
    probe(10, 1, "R5 mute");
    step(1, 128, 1, 60, 1, "R7 write muted");
    probe(130, 1, "R5 to zero");
    step(0, 0, 0, 0, 1, "R5 idle");
    probe(3, 1, "R5 floor");
    step(0, 0, 0, 0, 0, "R6 release idle");
    probe(70, 0, "R6 release ramp");
    step(1, -300, 0, 0, 0, "R7 at target");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule